// File: doc/BRIEF.md
# Page-Table Cache Miss Router

This unit sits behind the lookup pipeline of a page-table cache. Each cycle it takes one summarised lookup result (leaf hit, non-leaf second-level hit) together with the attributes of the request: translation kind, origin, whether it is a second-stage query raised by a walker, and its tag. It sends that request to exactly one of six consumers: the first-level TLB response path, the long-latency walker, the main walker, the second-stage walker, the second-stage response arbiter, or the miss queue. A prefetch that cannot be placed on a walker is dropped.

Every consumer uses a valid/ready handshake. The routing rules are evaluated side by side and resolve to a single destination. The request is held until that destination takes it. A small lock register keeps a stalled request pointed at the destination it first showed, even if a walker's readiness changes while it waits. The unit also compares the request tag with a refill that is in flight. A miss on the same tag is flagged as bypassed, and that flag travels with the request to every consumer.

Top module: `pgc_miss_router`

## Requirements
- R1: A request that is not a second-stage query and hits a leaf goes to the TLB response port, unless its translation kind is all-stages (code 2'b11).
- R2: An all-stages request whose first stage hits a leaf goes to the main walker when its origin is the miss queue (origin code 2'b01) and the main walker is ready. Otherwise it goes to the miss queue, or is dropped if it is a prefetch (origin code 2'b10).
- R3: A request with a leaf miss that is not bypassed, is not G-stage-only and hits the second level goes to the long-latency walker when that walker is ready. Otherwise it goes to the miss queue, or is dropped if it is a prefetch. For stage-1 (2'b01) and all-stages requests, the second-level hit input refers to the first stage.
- R4: A request with a leaf miss that is not bypassed, is not G-stage-only and misses the second level goes to the main walker only when its origin is the miss queue and the main walker is ready. Otherwise it goes to the miss queue, or is dropped if it is a prefetch. Origin codes 2'b00 and 2'b11 both count as the first-level TLB.
- R5: A G-stage-only request (code 2'b10) that is not a second-stage query, misses its leaf and is not bypassed always goes to the main walker, and stalls while that walker is busy.
- R6: A second-stage query goes to the second-stage response arbiter on a leaf hit and to the second-stage walker on a miss. It stalls while the chosen one is busy, and its id appears on `out_s2_id`.
- R7: `out_bypassed` is high exactly when the request misses its leaf while `rf_valid` is high and `rf_tag` equals `req_tag`. A bypassed request that is neither a prefetch nor a second-stage query goes to the miss queue. A bypassed prefetch is dropped.
- R8: A dropped request raises no destination valid and sees `req_ready` high.
- R9: At most one destination valid is high at a time. None is high while `req_valid` is low, including during and straight after reset.
- R10: `req_ready` equals the ready input of the single destination whose valid is high.
- R11: `out_tag` and `out_s2_id` carry `req_tag` and `req_s2_id` unchanged.
- R12: When a request is shown to a destination that does not accept it, the next cycle shows the same destination, provided the request is held. This holds even if walker readiness has changed meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup result present |
| req_ready | output | 1 | Lookup result consumed this cycle |
| req_tag | input | TAG_W | Virtual page tag of the request |
| req_xlate | input | 2 | Translation kind: 00 host, 01 stage-1, 10 G-stage-only, 11 all-stages |
| req_src | input | 2 | Origin: 00 first-level TLB, 01 miss queue, 10 prefetch, 11 first-level TLB |
| req_is_s2 | input | 1 | Second-stage query raised by a walker |
| req_s2_id | input | ID_W | Walker id for the second-stage reply |
| lk_leaf_hit | input | 1 | Leaf entry found (first stage for all-stages) |
| lk_l2_hit | input | 1 | Non-leaf second-level entry found |
| rf_valid | input | 1 | Refill in flight |
| rf_tag | input | TAG_W | Tag of the refill in flight |
| tlb_valid | output | 1 | Response to first-level TLB |
| tlb_ready | input | 1 | TLB response path ready |
| llptw_valid | output | 1 | Request to long-latency walker |
| llptw_ready | input | 1 | Long-latency walker ready |
| ptw_valid | output | 1 | Request to main walker |
| ptw_ready | input | 1 | Main walker ready |
| hptw_valid | output | 1 | Request to second-stage walker |
| hptw_ready | input | 1 | Second-stage walker ready |
| s2r_valid | output | 1 | Reply to second-stage response arbiter |
| s2r_ready | input | 1 | Second-stage response arbiter ready |
| mq_valid | output | 1 | Request to miss queue |
| mq_ready | input | 1 | Miss queue ready |
| out_tag | output | TAG_W | Tag forwarded to the destination |
| out_s2_id | output | ID_W | Walker id forwarded to the destination |
| out_bypassed | output | 1 | Bypass flag; on a second-stage miss it suppresses refill |

## Verification
The bench builds the router with an 8-bit tag, a 2-bit walker id and the stall lock enabled. With a tag that narrow, a refill tag drawn apart from the request tag still matches it now and then. The bench also forces a match on about half of the cycles with a refill in flight, so bypassed and clean misses both occur often, across every translation kind and origin. Ready inputs are redrawn on every cycle while a request is held. This keeps reaching the case where a walker becomes ready during a stall, which is the case the lock exists for.

// File: rtl/pgc_route_pkg.sv
package pgc_route_pkg;

   typedef enum logic [1:0] {
      XL_HOST = 2'b00,
      XL_S1   = 2'b01,
      XL_S2   = 2'b10,
      XL_ALL  = 2'b11
   } xlate_e;

   typedef enum logic [1:0] {
      SRC_L1  = 2'b00,
      SRC_MQ  = 2'b01,
      SRC_PF  = 2'b10,
      SRC_RSV = 2'b11
   } src_e;

   localparam int unsigned NDEST = 6;

   // index order is the bit order of the destination vectors
   typedef enum logic [2:0] {
      D_TLB   = 3'd0,
      D_LLPTW = 3'd1,
      D_PTW   = 3'd2,
      D_HPTW  = 3'd3,
      D_S2R   = 3'd4,
      D_MQ    = 3'd5,
      D_DROP  = 3'd6
   } dest_e;

endpackage

// File: rtl/pgc_route_decide.sv
module pgc_route_decide
   import pgc_route_pkg::*;
#(
   parameter int unsigned TAG_W = 27
) (
   input  logic [TAG_W-1:0] req_tag,
   input  logic [1:0]       req_xlate,
   input  logic [1:0]       req_src,
   input  logic             req_is_s2,
   input  logic             lk_leaf_hit,
   input  logic             lk_l2_hit,
   input  logic             rf_valid,
   input  logic [TAG_W-1:0] rf_tag,
   input  logic             llptw_rdy,
   input  logic             ptw_rdy,
   output dest_e            fresh_dest,
   output logic             bypassed
);

   if (TAG_W < 1) begin : g_bad_tag
      $error("pgc_route_decide: TAG_W must be at least 1");
   end

   xlate_e xl;
   src_e   src;
   dest_e  spill;
   logic   refill_same;

   assign xl          = xlate_e'(req_xlate);
   assign src         = src_e'(req_src);
   assign refill_same = rf_valid && (rf_tag == req_tag);

   always_comb begin
      bypassed = !lk_leaf_hit && refill_same;
      spill    = (src == SRC_PF) ? D_DROP : D_MQ;
      if (req_is_s2) begin
         fresh_dest = lk_leaf_hit ? D_S2R : D_HPTW;
      end else if (lk_leaf_hit && xl != XL_ALL) begin
         fresh_dest = D_TLB;
      end else if (lk_leaf_hit) begin
         fresh_dest = (src == SRC_MQ && ptw_rdy) ? D_PTW : spill;
      end else if (bypassed) begin
         fresh_dest = spill;
      end else if (xl == XL_S2) begin
         fresh_dest = D_PTW;
      end else if (lk_l2_hit) begin
         fresh_dest = llptw_rdy ? D_LLPTW : spill;
      end else begin
         fresh_dest = (src == SRC_MQ && ptw_rdy) ? D_PTW : spill;
      end
   end

endmodule

// File: rtl/pgc_route_hold.sv
module pgc_route_hold
   import pgc_route_pkg::*;
#(
   parameter bit LOCK_ON_STALL = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  req_valid,
   input  dest_e fresh_dest,
   input  logic  sel_ready,
   output dest_e cur_dest
);

   if (LOCK_ON_STALL) begin : g_lock
      logic  held_q;
      dest_e held_dest_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_q      <= 1'b0;
            held_dest_q <= D_DROP;
         end else if (req_valid && cur_dest != D_DROP && !sel_ready) begin
            held_q      <= 1'b1;
            held_dest_q <= cur_dest;
         end else begin
            held_q      <= 1'b0;
         end
      end

      assign cur_dest = held_q ? held_dest_q : fresh_dest;
   end else begin : g_free
      assign cur_dest = fresh_dest;
   end

endmodule

// File: rtl/pgc_dest_fanout.sv
module pgc_dest_fanout
   import pgc_route_pkg::*;
#(
   parameter int unsigned N = NDEST
) (
   input  logic         req_valid,
   input  dest_e        cur_dest,
   input  logic [N-1:0] dst_rdy,
   output logic [N-1:0] dst_vld,
   output logic         req_ready,
   output logic         sel_ready
);

   if (N != NDEST) begin : g_bad_n
      $error("pgc_dest_fanout: N must match the destination count");
   end

   for (genvar gi = 0; gi < N; gi++) begin : g_port
      assign dst_vld[gi] = req_valid && (cur_dest == dest_e'(gi));
   end

   always_comb begin
      sel_ready = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (cur_dest == dest_e'(i)) sel_ready = dst_rdy[i];
      end
   end

   assign req_ready = sel_ready;

endmodule

// File: rtl/pgc_miss_router.sv
module pgc_miss_router
   import pgc_route_pkg::*;
#(
   parameter int unsigned TAG_W         = 27,
   parameter int unsigned ID_W          = 1,
   parameter bit          LOCK_ON_STALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [TAG_W-1:0] req_tag,
   input  logic [1:0]       req_xlate,
   input  logic [1:0]       req_src,
   input  logic             req_is_s2,
   input  logic [ID_W-1:0]  req_s2_id,
   input  logic             lk_leaf_hit,
   input  logic             lk_l2_hit,
   input  logic             rf_valid,
   input  logic [TAG_W-1:0] rf_tag,
   output logic             tlb_valid,
   input  logic             tlb_ready,
   output logic             llptw_valid,
   input  logic             llptw_ready,
   output logic             ptw_valid,
   input  logic             ptw_ready,
   output logic             hptw_valid,
   input  logic             hptw_ready,
   output logic             s2r_valid,
   input  logic             s2r_ready,
   output logic             mq_valid,
   input  logic             mq_ready,
   output logic [TAG_W-1:0] out_tag,
   output logic [ID_W-1:0]  out_s2_id,
   output logic             out_bypassed
);

   if (ID_W < 1) begin : g_bad_id
      $error("pgc_miss_router: ID_W must be at least 1");
   end

   dest_e            fresh_dest;
   dest_e            cur_dest;
   logic             sel_ready;
   logic [NDEST-1:0] dst_rdy;
   logic [NDEST-1:0] dst_vld;

   assign dst_rdy = {mq_ready, s2r_ready, hptw_ready, ptw_ready, llptw_ready, tlb_ready};

   pgc_route_decide #(.TAG_W(TAG_W)) decide_i (
      .req_tag     (req_tag),
      .req_xlate   (req_xlate),
      .req_src     (req_src),
      .req_is_s2   (req_is_s2),
      .lk_leaf_hit (lk_leaf_hit),
      .lk_l2_hit   (lk_l2_hit),
      .rf_valid    (rf_valid),
      .rf_tag      (rf_tag),
      .llptw_rdy   (llptw_ready),
      .ptw_rdy     (ptw_ready),
      .fresh_dest  (fresh_dest),
      .bypassed    (out_bypassed)
   );

   pgc_route_hold #(.LOCK_ON_STALL(LOCK_ON_STALL)) hold_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .fresh_dest (fresh_dest),
      .sel_ready  (sel_ready),
      .cur_dest   (cur_dest)
   );

   pgc_dest_fanout #(.N(NDEST)) fanout_i (
      .req_valid (req_valid),
      .cur_dest  (cur_dest),
      .dst_rdy   (dst_rdy),
      .dst_vld   (dst_vld),
      .req_ready (req_ready),
      .sel_ready (sel_ready)
   );

   assign tlb_valid   = dst_vld[D_TLB];
   assign llptw_valid = dst_vld[D_LLPTW];
   assign ptw_valid   = dst_vld[D_PTW];
   assign hptw_valid  = dst_vld[D_HPTW];
   assign s2r_valid   = dst_vld[D_S2R];
   assign mq_valid    = dst_vld[D_MQ];
   assign out_tag     = req_tag;
   assign out_s2_id   = req_s2_id;

endmodule

// File: rtl/pgc_miss_router_chk.sv
module pgc_miss_router_chk #(
   parameter int unsigned N = 6
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_valid,
   input logic         req_ready,
   input logic [1:0]   req_xlate,
   input logic         req_is_s2,
   input logic         lk_leaf_hit,
   input logic         out_bypassed,
   input logic [N-1:0] dst_vld,
   input logic [N-1:0] dst_rdy
);

   assert_single_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dst_vld) && (req_valid || dst_vld == '0));

   assert_leaf_to_tlb_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_s2 && lk_leaf_hit && req_xlate != 2'b11) |-> dst_vld[0]);

   assert_s2_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_s2) |-> (dst_vld[3] || dst_vld[4]));

   assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && dst_vld != '0) |-> (req_ready == |(dst_vld & dst_rdy)));

   assert_drop_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && dst_vld == '0) |-> req_ready);

   assert_no_bypass_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_leaf_hit |-> !out_bypassed);

   assert_stall_keeps_dest_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (!req_valid || $stable(dst_vld)));

endmodule

bind pgc_miss_router pgc_miss_router_chk #(.N(pgc_route_pkg::NDEST)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_xlate    (req_xlate),
   .req_is_s2    (req_is_s2),
   .lk_leaf_hit  (lk_leaf_hit),
   .out_bypassed (out_bypassed),
   .dst_vld      (dst_vld),
   .dst_rdy      (dst_rdy)
);

// File: tb/pgc_miss_router_tb_top.sv
module pgc_miss_router_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TAG_W      = 8;
   localparam int ID_W       = 2;
   localparam int DROP       = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [TAG_W-1:0] req_tag = '0;
   logic [1:0]       req_xlate = 2'b00;
   logic [1:0]       req_src = 2'b00;
   logic             req_is_s2 = 1'b0;
   logic [ID_W-1:0]  req_s2_id = '0;
   logic             lk_leaf_hit = 1'b0;
   logic             lk_l2_hit = 1'b0;
   logic             rf_valid = 1'b0;
   logic [TAG_W-1:0] rf_tag = '0;
   logic [5:0]       rdy = '0;
   logic             tlb_valid, llptw_valid, ptw_valid, hptw_valid, s2r_valid, mq_valid;
   logic [TAG_W-1:0] out_tag;
   logic [ID_W-1:0]  out_s2_id;
   logic             out_bypassed;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int m_held = 0;
   int m_hsel = DROP;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgc_miss_router #(.TAG_W(TAG_W), .ID_W(ID_W), .LOCK_ON_STALL(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_tag(req_tag), .req_xlate(req_xlate), .req_src(req_src),
      .req_is_s2(req_is_s2), .req_s2_id(req_s2_id),
      .lk_leaf_hit(lk_leaf_hit), .lk_l2_hit(lk_l2_hit),
      .rf_valid(rf_valid), .rf_tag(rf_tag),
      .tlb_valid(tlb_valid), .tlb_ready(rdy[0]),
      .llptw_valid(llptw_valid), .llptw_ready(rdy[1]),
      .ptw_valid(ptw_valid), .ptw_ready(rdy[2]),
      .hptw_valid(hptw_valid), .hptw_ready(rdy[3]),
      .s2r_valid(s2r_valid), .s2r_ready(rdy[4]),
      .mq_valid(mq_valid), .mq_ready(rdy[5]),
      .out_tag(out_tag), .out_s2_id(out_s2_id), .out_bypassed(out_bypassed)
   );

   // behavioural routing reference: returns destination index, names the rule
   function automatic int ref_dest(output string rule);
      bit byp;
      bit pf;
      bit from_mq;
      int spill;
      byp     = !lk_leaf_hit && rf_valid && (rf_tag == req_tag);
      pf      = (req_src == 2'b10);
      from_mq = (req_src == 2'b01);
      spill   = pf ? DROP : 5;
      if (req_is_s2) begin
         rule = "R6";
         return lk_leaf_hit ? 4 : 3;
      end
      if (lk_leaf_hit && req_xlate != 2'b11) begin
         rule = "R1";
         return 0;
      end
      if (lk_leaf_hit) begin
         rule = "R2";
         return (from_mq && rdy[2]) ? 2 : spill;
      end
      if (byp) begin
         rule = "R7";
         return spill;
      end
      if (req_xlate == 2'b10) begin
         rule = "R5";
         return 2;
      end
      if (lk_l2_hit) begin
         rule = "R3";
         return rdy[1] ? 1 : spill;
      end
      rule = "R4";
      return (from_mq && rdy[2]) ? 2 : spill;
   endfunction

   task automatic check(input bit ok, input string rule, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", rule, what, act, exp);
      end
   endtask

   function automatic logic [5:0] vld_vec();
      return {mq_valid, s2r_valid, hptw_valid, ptw_valid, llptw_valid, tlb_valid};
   endfunction

   // compare just before the rising edge, then update the reference lock state
   task automatic step();
      string rule;
      int ed;
      logic [5:0] ev;
      logic er;
      logic eb;
      #(CLK_PERIOD/2 - 1);
      ed = ref_dest(rule);
      if (m_held != 0) begin
         ed = m_hsel;
         rule = "R12";
      end
      ev = (req_valid && ed != DROP) ? (6'b1 << ed) : 6'b0;
      er = (ed == DROP) ? 1'b1 : rdy[ed];
      eb = !lk_leaf_hit && rf_valid && (rf_tag == req_tag);
      check(vld_vec() == ev, (ed == DROP && req_valid) ? "R8" : rule,
            "destination valids", int'(vld_vec()), int'(ev));
      if (req_valid)
         check(req_ready == er, (ed == DROP) ? "R8" : "R10",
               "req_ready", int'(req_ready), int'(er));
      check(out_bypassed == eb, "R7", "bypass flag", int'(out_bypassed), int'(eb));
      check(out_tag == req_tag && out_s2_id == req_s2_id, "R11", "pass-through tag",
            int'({out_s2_id, out_tag}), int'({req_s2_id, req_tag}));
      @(posedge clk);
      if (req_valid && ed != DROP && !rdy[ed]) begin
         m_held = 1;
         m_hsel = ed;
      end else begin
         m_held = 0;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(vld_vec() == 6'b0, "R9", "valids in reset", int'(vld_vec()), 0);
      rst_n = 1'b1;
      step();   // idle after reset, R9

      // R12 directed: stall on miss queue, main walker becomes ready meanwhile
      req_valid = 1'b1; req_xlate = 2'b00; req_src = 2'b01;
      lk_leaf_hit = 1'b0; lk_l2_hit = 1'b0; rf_valid = 1'b0;
      req_tag = 8'h3c; rdy = 6'b000000;
      step();               // R4: miss queue shown, not taken
      rdy = 6'b000100;
      step();               // R12: still miss queue
      rdy = 6'b100100;
      step();               // accepted by miss queue
      // R5 directed: G-stage-only miss stalls on main walker
      req_xlate = 2'b10; req_src = 2'b00; rdy = 6'b111011;
      step();
      rdy = 6'b111111;
      step();
      // R8 directed: bypassed prefetch
      req_xlate = 2'b01; req_src = 2'b10; rf_valid = 1'b1; rf_tag = req_tag;
      rdy = 6'b000000;
      step();

      for (int n = 0; n < 4000; n++) begin
         if (m_held == 0) begin
            req_valid   = ($urandom_range(0, 99) < 85);
            req_tag     = TAG_W'($urandom);
            req_xlate   = 2'($urandom);
            req_src     = 2'($urandom);
            req_is_s2   = ($urandom_range(0, 4) == 0);
            req_s2_id   = ID_W'($urandom);
            lk_leaf_hit = ($urandom_range(0, 2) == 0);
            lk_l2_hit   = $urandom_range(0, 1) == 1;
            rf_valid    = $urandom_range(0, 1) == 1;
            rf_tag      = ($urandom_range(0, 1) == 1) ? req_tag : TAG_W'($urandom);
         end
         rdy = 6'($urandom);
         step();
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule